// File: doc/BRIEF.md
# Fixed-Size Command Intake Front-End

This block sits between a user's memory-mapped request port and a storage transport engine. Each user request is a Write or a Read of one fixed 8 KB chunk, addressed in 512-byte units. A Write carries its payload as 512 beats of 128 bits, and the first beat travels in the same cycle as the request. A single wait-request output pushes back on both the command and the data. While it is high, the user holds the address, the strobe and the current data beat.

Once a command is accepted, the block stalls the port for a fixed pre-processing window of six cycles. It then offers a descriptor (direction and address) downstream over a valid/ready handshake. For a Write it then streams the remaining 511 beats out on a registered beat port, and the user may leave gaps between beats. A counter tracks the outstanding commands. It rises on each acceptance and falls on each completion pulse from the transport. No new command is taken at 128 outstanding, and no Read is taken while the read-buffer credit input is low. Busy reports whether any command is still in flight. Misaligned addresses and illegal strobe combinations are refused and raise a sticky error flag.

Top module: `chunk_cmd_front`

## Requirements
- R1: After reset, busy, protoErr, issValid and beatValid are 0, and waitReq is 1 while no request is presented.
- R2: In the idle phase, waitReq is 0 (the request is accepted at that clock edge) exactly when one strobe is high, reqAddr[3:0] is 0000, fewer than 128 commands are outstanding, and for a Read rdRoom is 1. Otherwise waitReq is 1.
- R3: After an acceptance, waitReq stays 1 for the next 6 cycles and then issValid rises. waitReq stays 1 until the descriptor handshake completes.
- R4: issValid holds, with issAddr stable, until issReady is 1. issWrite is 1 for a Write and 0 for a Read, and issAddr equals the accepted reqAddr.
- R5: A Write moves exactly 512 beats: the one in the acceptance cycle, then one per cycle with reqWrite 1 in the data phase (waitReq 0). Gaps with reqWrite 0 consume nothing. Each consumed beat appears on beatData with beatValid 1 one cycle later, and beatLast marks the 512th beat.
- R6: With 128 commands outstanding, no Write or Read is accepted. A cmplPulse lowers the count by one so that a waiting request is then accepted.
- R7: A Read is not accepted while rdRoom is 0. The request waits and is accepted once rdRoom returns to 1.
- R8: busy is 1 from the cycle after an acceptance until the block is idle and every outstanding command has completed.
- R9: protoErr becomes 1 and stays 1 until reset after any of these: both strobes high in one cycle, a strobe in the idle phase with reqAddr[3:0] not 0000, or reqRead high in a Write's data phase. Such a request is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqAddr | input | 48 | Request address in 512-byte units |
| reqWrite | input | 1 | Write strobe, also qualifies each data beat |
| reqRead | input | 1 | Read strobe |
| reqWrData | input | 128 | Write data beat |
| waitReq | output | 1 | 1: command or beat not taken this cycle |
| busy | output | 1 | Commands in flight or intake not idle |
| protoErr | output | 1 | Sticky protocol error |
| rdRoom | input | 1 | Read buffer can take one more Read |
| issValid | output | 1 | Descriptor valid |
| issReady | input | 1 | Downstream takes the descriptor |
| issWrite | output | 1 | Descriptor direction, 1 = Write |
| issAddr | output | 48 | Descriptor address |
| beatValid | output | 1 | Forwarded write beat valid |
| beatData | output | 128 | Forwarded write beat |
| beatLast | output | 1 | Last of the 512 beats |
| cmplPulse | input | 1 | One command completed downstream |

## Verification
On every cycle, the assertions check the following: the outstanding count never exceeds 128, and it stays pinned at 128 until a completion arrives. An acceptance is followed by a stalled port and a raised busy flag. A pending descriptor is held until it is taken, and the error flag never clears. The bench scenarios show the rest: the exact stall length, the 512-beat count with gaps, the data order and last marker, refusal under credit starvation and at the full count, and release after a completion. They also show each class of protocol violation being refused.

// File: rtl/chunk_cmd_pkg.sv
package chunk_cmd_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_STALL, PH_ISSUE, PH_DATA} phase_t;

  typedef struct packed {
    logic latchCmd;
    logic takeBeat;
    logic lastBeat;
  } dp_ctl_t;
endpackage

// File: rtl/chunk_cmd_ctrl.sv
module chunk_cmd_ctrl
  import chunk_cmd_pkg::*;
#(
  parameter int BEATS      = 512,
  parameter int MAX_OUT    = 128,
  parameter int STALL_CYC  = 6,
  parameter int ALIGN_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ALIGN_BITS-1:0] addrLow,
  input  logic                  reqWrite,
  input  logic                  reqRead,
  input  logic                  rdRoom,
  input  logic                  issReady,
  input  logic                  cmplPulse,
  output logic                  waitReq,
  output logic                  busy,
  output logic                  protoErr,
  output logic                  issValid,
  output dp_ctl_t               ctl
);
  localparam int CW = $clog2(MAX_OUT + 1);
  localparam int BW = $clog2(BEATS);
  localparam int SW = $clog2(STALL_CYC + 1);
  localparam logic [CW-1:0] FULL_CNT  = CW'(MAX_OUT);
  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);
  localparam logic [SW-1:0] LAST_STL  = SW'(STALL_CYC - 1);

  phase_t        phase;
  logic          curIsWrite;
  logic [CW-1:0] outCnt;
  logic [SW-1:0] stallCnt;
  logic [BW-1:0] beatCnt;

  logic aligned, creditOk, goodReq, accept, beatTake, badNow, dec;

  always_comb begin
    aligned  = (addrLow == '0);
    creditOk = (outCnt != FULL_CNT);
    goodReq  = (reqWrite ^ reqRead) & aligned & creditOk & (~reqRead | rdRoom);
    accept   = (phase == PH_IDLE) & goodReq;
    beatTake = (phase == PH_DATA) & reqWrite;
    badNow   = (reqWrite & reqRead)
             | ((phase == PH_IDLE) & (reqWrite | reqRead) & ~aligned)
             | ((phase == PH_DATA) & reqRead);
    dec      = cmplPulse & (outCnt != '0);
    unique case (phase)
      PH_IDLE: waitReq = ~goodReq;
      PH_DATA: waitReq = 1'b0;
      default: waitReq = 1'b1;
    endcase
    ctl.latchCmd = accept;
    ctl.takeBeat = (accept & reqWrite) | beatTake;
    ctl.lastBeat = beatTake & (beatCnt == LAST_BEAT);
    issValid     = (phase == PH_ISSUE);
    busy         = (phase != PH_IDLE) | (outCnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      curIsWrite <= 1'b0;
      stallCnt   <= '0;
      beatCnt    <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase      <= PH_STALL;
          curIsWrite <= reqWrite;
          stallCnt   <= '0;
          beatCnt    <= BW'(1);
        end
        PH_STALL: begin
          if (stallCnt == LAST_STL) phase <= PH_ISSUE;
          else stallCnt <= stallCnt + SW'(1);
        end
        PH_ISSUE: if (issReady) phase <= curIsWrite ? PH_DATA : PH_IDLE;
        PH_DATA: if (beatTake) begin
          beatCnt <= beatCnt + BW'(1);
          if (beatCnt == LAST_BEAT) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outCnt <= '0;
    else if (accept && !dec) outCnt <= outCnt + CW'(1);
    else if (!accept && dec) outCnt <= outCnt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) protoErr <= 1'b0;
    else if (badNow) protoErr <= 1'b1;
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    outCnt <= FULL_CNT);
  assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outCnt == FULL_CNT && !cmplPulse) |=> outCnt == FULL_CNT);
  assert_stall_after_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> waitReq);
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy);
  assert_issue_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && !issReady) |=> issValid);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
endmodule

// File: rtl/chunk_cmd_dpath.sv
module chunk_cmd_dpath
  import chunk_cmd_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic              issValid,
  output logic              issWrite,
  output logic [ADDR_W-1:0] issAddr,
  output logic              beatValid,
  output logic [DATA_W-1:0] beatData,
  output logic              beatLast
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      issWrite <= 1'b0;
      issAddr  <= '0;
    end else if (ctl.latchCmd) begin
      issWrite <= reqWrite;
      issAddr  <= reqAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatValid <= 1'b0;
      beatLast  <= 1'b0;
      beatData  <= '0;
    end else begin
      beatValid <= ctl.takeBeat;
      beatLast  <= ctl.lastBeat;
      if (ctl.takeBeat) beatData <= reqWrData;
    end
  end

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && $past(issValid)) |-> $stable(issAddr));
  assert_last_is_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    beatLast |-> beatValid);
endmodule

// File: rtl/chunk_cmd_front.sv
module chunk_cmd_front
  import chunk_cmd_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int DATA_W     = 128,
  parameter int BEATS      = 512,
  parameter int MAX_OUT    = 128,
  parameter int STALL_CYC  = 6,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqRead,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              waitReq,
  output logic              busy,
  output logic              protoErr,
  input  logic              rdRoom,
  output logic              issValid,
  input  logic              issReady,
  output logic              issWrite,
  output logic [ADDR_W-1:0] issAddr,
  output logic              beatValid,
  output logic [DATA_W-1:0] beatData,
  output logic              beatLast,
  input  logic              cmplPulse
);
  dp_ctl_t ctl;

  chunk_cmd_ctrl #(
    .BEATS(BEATS), .MAX_OUT(MAX_OUT), .STALL_CYC(STALL_CYC), .ALIGN_BITS(ALIGN_BITS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .addrLow(reqAddr[ALIGN_BITS-1:0]),
    .reqWrite(reqWrite), .reqRead(reqRead), .rdRoom(rdRoom),
    .issReady(issReady), .cmplPulse(cmplPulse), .waitReq(waitReq),
    .busy(busy), .protoErr(protoErr), .issValid(issValid), .ctl(ctl)
  );

  chunk_cmd_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqWrData(reqWrData), .issValid(issValid), .issWrite(issWrite),
    .issAddr(issAddr), .beatValid(beatValid), .beatData(beatData), .beatLast(beatLast)
  );
endmodule

// File: tb/test_chunk_cmd_front.sv
module test_chunk_cmd_front;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [47:0]  reqAddr = '0;
  logic         reqWrite = 1'b0, reqRead = 1'b0;
  logic [127:0] reqWrData = '0;
  logic         waitReq, busy, protoErr, issValid, issWrite, beatValid, beatLast;
  logic [47:0]  issAddr;
  logic [127:0] beatData;
  logic         rdRoom = 1'b1, issReady = 1'b1, cmplPulse = 1'b0;

  int nCmp = 0, nBad = 0, cyc = 0;

  chunk_cmd_front i_chunk_cmd_front (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqWrite(reqWrite), .reqRead(reqRead),
    .reqWrData(reqWrData), .waitReq(waitReq), .busy(busy), .protoErr(protoErr),
    .rdRoom(rdRoom), .issValid(issValid), .issReady(issReady), .issWrite(issWrite),
    .issAddr(issAddr), .beatValid(beatValid), .beatData(beatData), .beatLast(beatLast),
    .cmplPulse(cmplPulse)
  );

  always #5 clk = ~clk;

  // behavioural reference: 0 idle, 1 stall, 2 issue, 3 data
  int mPh = 0, mSt = 0, mBeats = 0, mOut = 0;
  bit mErr = 0, mIsW = 0, mBV = 0, mBL = 0;
  logic [47:0]  mAddr = '0;
  logic [127:0] mBD = '0;

  function automatic bit mGood();
    return (reqWrite ^ reqRead) && reqAddr[3:0] == 4'h0 && mOut < 128 && (!reqRead || rdRoom);
  endfunction

  function automatic bit mWait();
    if (mPh == 0) return !mGood();
    if (mPh == 3) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mSt = 0; mBeats = 0; mOut = 0; mErr = 0; mBV = 0; mBL = 0;
    end else begin
      bit g, d;
      g = mGood();
      d = cmplPulse && mOut > 0;
      if ((reqWrite && reqRead) || (mPh == 0 && (reqWrite || reqRead) && reqAddr[3:0] != 0)
          || (mPh == 3 && reqRead)) mErr = 1;
      mBV = 0; mBL = 0;
      case (mPh)
        0: if (g) begin
          mPh = 1; mSt = 0; mIsW = reqWrite; mAddr = reqAddr; mOut++;
          if (reqWrite) begin mBV = 1; mBD = reqWrData; mBeats = 1; end
        end
        1: if (mSt == 5) mPh = 2; else mSt++;
        2: if (issReady) mPh = mIsW ? 3 : 0;
        3: if (reqWrite) begin
          mBV = 1; mBD = reqWrData; mBL = (mBeats == 511);
          if (mBeats == 511) mPh = 0;
          mBeats++;
        end
        default: mPh = 0;
      endcase
      if (d) mOut--;
    end
  end

  task automatic cmp(string tag, string nm, logic [127:0] act, logic [127:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (rstN) begin
      string wTag;
      if (mPh == 0 && mOut >= 128 && (reqWrite || reqRead)) wTag = "R6";
      else if (mPh == 0 && reqRead && !rdRoom) wTag = "R7";
      else if (mPh == 0) wTag = "R2";
      else wTag = "R3";
      cmp(wTag, "waitReq", waitReq, mWait());
      cmp("R3", "issValid", issValid, mPh == 2);
      if (mPh == 2) begin
        cmp("R4", "issWrite", issWrite, mIsW);
        cmp("R4", "issAddr", issAddr, mAddr);
      end
      cmp("R8", "busy", busy, mPh != 0 || mOut != 0);
      cmp("R9", "protoErr", protoErr, mErr);
      cmp("R5", "beatValid", beatValid, mBV);
      if (mBV) begin
        cmp("R5", "beatData", beatData, mBD);
        cmp("R5", "beatLast", beatLast, mBL);
      end
    end
  end

  function automatic logic [127:0] mk(logic [47:0] a, int b);
    return {a, 16'hA5C3, 32'(b), 32'(b * 7 + 3)};
  endfunction

  task automatic waitTaken();
    #1;
    while (waitReq) begin @(negedge clk); #1; end
  endtask

  // R5: full 512-beat write; gapEvery inserts idle beats, badRd puts a read strobe in a gap
  task automatic doWrite(logic [47:0] a, int gapEvery, bit badRd);
    @(negedge clk); reqAddr = a; reqWrite = 1; reqWrData = mk(a, 0);
    waitTaken();
    for (int b = 1; b < 512; b++) begin
      @(negedge clk);
      if (gapEvery > 0 && b % gapEvery == 0) begin
        reqWrite = 0; reqRead = badRd;
        @(negedge clk); reqRead = 0;
      end
      reqWrite = 1; reqWrData = mk(a, b);
      waitTaken();
    end
    @(negedge clk); reqWrite = 0;
  endtask

  task automatic doRead(logic [47:0] a);
    @(negedge clk); reqAddr = a; reqRead = 1;
    waitTaken();
    @(negedge clk); reqRead = 0;
  endtask

  task automatic complete(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cmplPulse = 1;
      @(negedge clk); cmplPulse = 0;
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    settle(4);
    #3;
    // R1: reset state
    cmp("R1", "busy", busy, 0);
    cmp("R1", "protoErr", protoErr, 0);
    cmp("R1", "issValid", issValid, 0);
    cmp("R1", "beatValid", beatValid, 0);
    cmp("R1", "waitReq", waitReq, 1);
    @(negedge clk); rstN = 1;
    settle(2);

    // R3/R4: write with delayed descriptor take, R5 gaps
    issReady = 0;
    fork
      doWrite(48'h10, 100, 0);
      begin settle(14); issReady = 1; end
    join
    settle(3);
    complete(1);
    settle(3);

    // R7: read starved of credit then released
    rdRoom = 0;
    fork
      doRead(48'h20);
      begin settle(5); rdRoom = 1; end
    join
    settle(10);
    complete(1);
    settle(3);

    // R6: fill to 128 outstanding reads
    for (int k = 0; k < 128; k++) doRead(48'(k * 16 + 48'h1000));
    settle(10);
    @(negedge clk); reqAddr = 48'h3000; reqWrite = 1; reqWrData = mk(48'h3000, 0);
    settle(4);
    @(negedge clk); reqWrite = 0; reqAddr = 48'h3010; reqRead = 1;
    settle(4);
    cmplPulse = 1;
    @(negedge clk); cmplPulse = 0;
    waitTaken();
    @(negedge clk); reqRead = 0;
    settle(10);
    complete(128);
    settle(4);

    // R5: back-to-back write with no gaps
    doWrite(48'h2000, 0, 0);
    settle(3);
    complete(1);

    // R9: misaligned, both strobes, read inside write data phase
    @(negedge clk); reqAddr = 48'h15; reqRead = 1;
    settle(2);
    @(negedge clk); reqRead = 0; reqAddr = 48'h40; reqWrite = 1; reqRead = 1;
    @(negedge clk); reqWrite = 0; reqRead = 0;
    settle(3);
    doWrite(48'h4000, 200, 1);
    settle(3);
    complete(1);
    settle(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule